// File: doc/BRIEF.md
# Reference Clock Monitor with Priority Failover and Holdover

This block watches a small set of candidate reference clocks and decides which one the system should lock to. Each candidate's rising edges are counted in its own clock domain. The count crosses into the domain of a stable local reference clock through a Gray-coded synchronizer. There, a free-running gate of fixed length cuts the count stream into measurement windows. A window is good when the number of candidate edges it holds lies inside a programmable pair of bounds. The bounds are set by software from the allowed frequency offset; a typical setting is a few ppm such as ±4.6 ppm, scaled to the gate length. A separate idle timer declares loss of signal as soon as a candidate's count stops advancing, without waiting for the window to close.

A candidate that fails either test is disqualified at once. It is trusted again only after a programmable run of consecutive good windows. The active selection is always the lowest-numbered qualified candidate, so it moves to the next healthy input when the active one fails. It moves back when a higher-priority input requalifies. When no candidate is qualified, the block raises a holdover flag and keeps the last selection index.

The frequency estimate is a block average of the active candidate's good windows, with extra fractional bits. It stops changing for as long as holdover lasts. The control and status pins are plain levels. No data stream with flow control passes through the block, so no back-pressure rules apply.

Top module: `refclk_guard`

## Requirements
- R1: While and right after reset, `holdover` is 1, `cand_ok` is all zero, `sel_idx` is 0 and `freq_est` is 0.
- R2: Every GATE_CYCLES cycles of `ref_clk`, each candidate's rising-edge count for that window is compared with `cnt_min` and `cnt_max`, both bounds inclusive. A window outside the bounds clears that candidate's `cand_ok` at the end of the window.
- R3: A candidate whose synchronized edge count does not advance for more than `los_tmo` reference cycles loses `cand_ok` without waiting for the window to end.
- R4: A disqualified candidate regains `cand_ok` only after `requal_n` consecutive good windows that have no loss of signal in them. A value of 0 acts as 1.
- R5: When any candidate is qualified, `sel_idx` is the lowest index whose `cand_ok` bit was 1 one cycle earlier. Index 0 has the highest priority, and a recovered higher-priority candidate takes the selection back.
- R6: `holdover` is 1 exactly when no `cand_ok` bit was 1 one cycle earlier. During holdover, `sel_idx` keeps its last value.
- R7: `freq_est` is an unsigned fixed-point value with HIST_LOG2 fractional bits. It equals the sum of 2^HIST_LOG2 consecutive good window counts of the active candidate, so it is their mean. The partial sum restarts when the selection changes or holdover begins.
- R8: `freq_est` does not change while `holdover` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Stable local reference clock; all outputs are in this domain |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| cand_clk | input | N_CAND | Candidate clocks, bit i is candidate i |
| cnt_min | input | CNT_W | Lowest acceptable edge count per window |
| cnt_max | input | CNT_W | Highest acceptable edge count per window |
| los_tmo | input | TMO_W | Reference cycles without count advance before loss of signal |
| requal_n | input | STREAK_W | Consecutive good windows needed to requalify |
| sel_idx | output | IDX_W | Index of the active candidate |
| cand_ok | output | N_CAND | Per-candidate qualified flag |
| holdover | output | 1 | No candidate qualified |
| freq_est | output | CNT_W+HIST_LOG2 | Averaged window count of the active candidate |

## Verification
The active candidate can be disqualified in the same cycle that the replacement is chosen. The selector resolves both from one qualified vector, so it must not pass through holdover when another input is still healthy. The bench provokes this with a ratio drift on candidate 0 and with stopping candidate 0, while candidates 1 to 3 stay good. In both cases `sel_idx` must move to 1 with `holdover` low throughout. The bench also collapses every candidate at the same window end by narrowing the count bounds, and it requires holdover to be entered and the estimate to stay frozen.

// File: rtl/refmon_pkg.sv
package refmon_pkg;
  // Counters are at most 32 bits wide; narrower ones are zero-extended.
  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/rm_edge_counter.sv
module rm_edge_counter import refmon_pkg::*; #(
  parameter int CNT_W = 12
) (
  input  logic             cand_clk,
  input  logic             ref_clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] count_ref
);
  logic [CNT_W-1:0] bin_q, gray_q, sync1_q, sync2_q;

  // candidate domain: binary counter with a registered Gray copy
  always_ff @(posedge cand_clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_q + 1'b1;
      gray_q <= CNT_W'(bin_to_gray(32'(bin_q + 1'b1)));
    end
  end

  // reference domain: two-flop synchronizer, then decode
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q   <= '0;
      sync2_q   <= '0;
      count_ref <= '0;
    end else begin
      sync1_q   <= gray_q;
      sync2_q   <= sync1_q;
      count_ref <= CNT_W'(gray_to_bin(32'(sync2_q)));
    end
  end
endmodule

// File: rtl/rm_qualifier.sv
module rm_qualifier #(
  parameter int CNT_W    = 12,
  parameter int TMO_W    = 8,
  parameter int STREAK_W = 4
) (
  input  logic                ref_clk,
  input  logic                rst_n,
  input  logic [CNT_W-1:0]    count,
  input  logic                win_end,
  input  logic [CNT_W-1:0]    cnt_min,
  input  logic [CNT_W-1:0]    cnt_max,
  input  logic [TMO_W-1:0]    los_tmo,
  input  logic [STREAK_W-1:0] requal_n,
  output logic                ok,
  output logic                win_good,
  output logic [CNT_W-1:0]    win_delta
);
  localparam logic [STREAK_W-1:0] STREAK_MAX = '1;

  logic [CNT_W-1:0]    last_q, start_q;
  logic [TMO_W-1:0]    idle_q;
  logic                los_q, seen_los_q;
  logic [STREAK_W-1:0] streak_q;
  logic [STREAK_W:0]   streak_inc;

  assign win_delta  = count - start_q;
  assign win_good   = !los_q && !seen_los_q && (win_delta >= cnt_min) && (win_delta <= cnt_max);
  assign streak_inc = {1'b0, streak_q} + 1'b1;

  // loss-of-signal idle timer
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      idle_q <= '0;
      los_q  <= 1'b0;
    end else begin
      last_q <= count;
      if (count != last_q) begin
        idle_q <= '0;
        los_q  <= 1'b0;
      end else if (idle_q >= los_tmo) begin
        los_q  <= 1'b1;
      end else begin
        idle_q <= idle_q + 1'b1;
      end
    end
  end

  // window measurement and requalification streak
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q    <= '0;
      streak_q   <= '0;
      ok         <= 1'b0;
      seen_los_q <= 1'b0;
    end else if (win_end) begin
      start_q    <= count;
      seen_los_q <= los_q;
      if (!win_good) begin
        streak_q <= '0;
        ok       <= 1'b0;
      end else begin
        if (streak_q != STREAK_MAX) streak_q <= streak_inc[STREAK_W-1:0];
        if (streak_inc >= {1'b0, requal_n}) ok <= 1'b1;
      end
    end else if (los_q) begin
      seen_los_q <= 1'b1;
      streak_q   <= '0;
      ok         <= 1'b0;
    end
  end
endmodule

// File: rtl/rm_history.sv
module rm_history #(
  parameter int CNT_W     = 12,
  parameter int HIST_LOG2 = 2,
  localparam int EST_W    = CNT_W + HIST_LOG2
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             sample_en,
  input  logic [CNT_W-1:0] sample,
  output logic [EST_W-1:0] est
);
  localparam logic [HIST_LOG2:0] LAST = (HIST_LOG2+1)'((1 << HIST_LOG2) - 1);

  logic [EST_W-1:0]   acc_q;
  logic [HIST_LOG2:0] n_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      n_q   <= '0;
      est   <= '0;
    end else if (restart) begin
      acc_q <= '0;
      n_q   <= '0;
    end else if (sample_en) begin
      if (n_q == LAST) begin
        est   <= acc_q + EST_W'(sample);
        acc_q <= '0;
        n_q   <= '0;
      end else begin
        acc_q <= acc_q + EST_W'(sample);
        n_q   <= n_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/refclk_guard.sv
module refclk_guard #(
  parameter int N_CAND      = 4,
  parameter int CNT_W       = 12,
  parameter int TMO_W       = 8,
  parameter int STREAK_W    = 4,
  parameter int GATE_CYCLES = 64,
  parameter int HIST_LOG2   = 2,
  localparam int IDX_W      = (N_CAND > 1) ? $clog2(N_CAND) : 1,
  localparam int EST_W      = CNT_W + HIST_LOG2
) (
  input  logic                ref_clk,
  input  logic                rst_n,
  input  logic [N_CAND-1:0]   cand_clk,
  input  logic [CNT_W-1:0]    cnt_min,
  input  logic [CNT_W-1:0]    cnt_max,
  input  logic [TMO_W-1:0]    los_tmo,
  input  logic [STREAK_W-1:0] requal_n,
  output logic [IDX_W-1:0]    sel_idx,
  output logic [N_CAND-1:0]   cand_ok,
  output logic                holdover,
  output logic [EST_W-1:0]    freq_est
);
  localparam int GATE_W = (GATE_CYCLES > 1) ? $clog2(GATE_CYCLES) : 1;

  logic [GATE_W-1:0] gate_q;
  logic              win_end;
  logic [N_CAND-1:0] ok_w, good_w;
  logic [CNT_W-1:0]  delta_w [N_CAND];
  logic [IDX_W-1:0]  pick;
  logic              any_ok, restart, sample_en;

  assign win_end = (gate_q == GATE_W'(GATE_CYCLES - 1));

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)       gate_q <= '0;
    else if (win_end) gate_q <= '0;
    else              gate_q <= gate_q + 1'b1;
  end

  for (genvar g = 0; g < N_CAND; g++) begin : g_cand
    logic [CNT_W-1:0] cnt_w;
    rm_edge_counter #(.CNT_W(CNT_W)) u_cnt (
      .cand_clk (cand_clk[g]),
      .ref_clk  (ref_clk),
      .rst_n    (rst_n),
      .count_ref(cnt_w)
    );
    rm_qualifier #(.CNT_W(CNT_W), .TMO_W(TMO_W), .STREAK_W(STREAK_W)) u_qual (
      .ref_clk  (ref_clk),
      .rst_n    (rst_n),
      .count    (cnt_w),
      .win_end  (win_end),
      .cnt_min  (cnt_min),
      .cnt_max  (cnt_max),
      .los_tmo  (los_tmo),
      .requal_n (requal_n),
      .ok       (ok_w[g]),
      .win_good (good_w[g]),
      .win_delta(delta_w[g])
    );
  end

  // fixed priority: lowest index wins
  always_comb begin
    pick = '0;
    for (int i = N_CAND - 1; i >= 0; i--) begin
      if (ok_w[i]) pick = IDX_W'(i);
    end
  end

  assign any_ok = |ok_w;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_idx  <= '0;
      holdover <= 1'b1;
    end else begin
      holdover <= !any_ok;
      if (any_ok) sel_idx <= pick;
    end
  end

  assign cand_ok   = ok_w;
  assign restart   = !any_ok || (pick != sel_idx);
  assign sample_en = win_end && !holdover && good_w[sel_idx];

  rm_history #(.CNT_W(CNT_W), .HIST_LOG2(HIST_LOG2)) u_hist (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .sample_en(sample_en),
    .sample   (delta_w[sel_idx]),
    .est      (freq_est)
  );
endmodule

// File: rtl/refclk_guard_chk.sv
module refclk_guard_chk #(
  parameter int N_CAND = 4,
  parameter int IDX_W  = 2,
  parameter int EST_W  = 14
) (
  input logic              ref_clk,
  input logic              rst_n,
  input logic [N_CAND-1:0] cand_ok,
  input logic [IDX_W-1:0]  sel_idx,
  input logic              holdover,
  input logic [EST_W-1:0]  freq_est
);
  // R6
  holdover_flag_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    holdover == ($past(cand_ok) == '0));

  // R5
  sel_ok_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !holdover |-> ((($past(cand_ok) >> sel_idx) & N_CAND'(1)) == N_CAND'(1)));

  // R5
  sel_prio_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !holdover |-> (($past(cand_ok) & ((N_CAND'(1) << sel_idx) - N_CAND'(1))) == '0));

  // R8
  est_frozen_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (holdover && $past(holdover)) |-> $stable(freq_est));

  // R6
  sel_hold_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (holdover && $past(holdover)) |-> $stable(sel_idx));
endmodule

bind refclk_guard refclk_guard_chk #(.N_CAND(N_CAND), .IDX_W(IDX_W), .EST_W(EST_W)) u_chk (
  .ref_clk (ref_clk),
  .rst_n   (rst_n),
  .cand_ok (cand_ok),
  .sel_idx (sel_idx),
  .holdover(holdover),
  .freq_est(freq_est)
);

// File: tb/refclk_guard_tb.sv
`timescale 1ns/1ps
module refclk_guard_tb;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  wire  [N-1:0] cclk;
  logic [11:0] cnt_min = 12'd31;
  logic [11:0] cnt_max = 12'd33;
  logic [7:0]  los_tmo = 8'd20;
  logic [3:0]  requal_n = 4'd2;
  logic [1:0]  sel_idx;
  logic [N-1:0] cand_ok;
  logic        holdover;
  logic [13:0] freq_est;

  bit en   [N];
  int half [N];
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : gc
    logic c = 1'b0;
    initial forever begin
      if (en[g]) begin
        #(half[g]);
        c = ~c;
      end else begin
        #1;
      end
    end
    assign cclk[g] = c;
  end

  refclk_guard u_dut (
    .ref_clk (clk),
    .rst_n   (rst_n),
    .cand_clk(cclk),
    .cnt_min (cnt_min),
    .cnt_max (cnt_max),
    .los_tmo (los_tmo),
    .requal_n(requal_n),
    .sel_idx (sel_idx),
    .cand_ok (cand_ok),
    .holdover(holdover),
    .freq_est(freq_est)
  );

  task automatic chk(input bit cond, input string req, input longint act, input longint exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // advance n clock edges, then sample away from the edge
  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    for (int i = 0; i < N; i++) begin
      en[i] = 0;
      half[i] = 5;
    end
    rst_n = 0;
    wait_cyc(4);
    chk(holdover == 1'b1, "R1 holdover", holdover, 1);
    chk(cand_ok == '0,    "R1 cand_ok", cand_ok, 0);
    chk(sel_idx == 2'd0,  "R1 sel_idx", sel_idx, 0);
    chk(freq_est == '0,   "R1 freq_est", freq_est, 0);
    rst_n = 1;
  endtask

  task automatic t_qualify();
    for (int i = 0; i < N; i++) en[i] = 1;
    wait_cyc(400);
    chk(cand_ok == 4'hF, "R4 all qualify", cand_ok, 15);
    chk(sel_idx == 2'd0, "R5 top priority", sel_idx, 0);
    chk(holdover == 1'b0, "R6 no holdover", holdover, 0);
  endtask

  task automatic t_drift();
    half[0] = 4;  // 40 edges per window, above cnt_max
    wait_cyc(150);
    chk(cand_ok[0] == 1'b0, "R2 drift rejects", cand_ok[0], 0);
    chk(sel_idx == 2'd1,    "R5 failover to 1", sel_idx, 1);
    chk(holdover == 1'b0,   "R6 failover without holdover", holdover, 0);
  endtask

  task automatic t_requal();
    half[0] = 5;
    wait_cyc(64);
    chk(cand_ok[0] == 1'b0, "R4 not yet requalified", cand_ok[0], 0);
    wait_cyc(300);
    chk(cand_ok[0] == 1'b1, "R4 requalified", cand_ok[0], 1);
    chk(sel_idx == 2'd0,    "R5 revert to 0", sel_idx, 0);
  endtask

  task automatic t_history();
    wait_cyc(700);
    chk(freq_est >= 14'd127 && freq_est <= 14'd129, "R7 average 32.00", freq_est, 128);
  endtask

  task automatic t_los();
    en[0] = 0;
    wait_cyc(40);
    chk(cand_ok[0] == 1'b0, "R3 loss of signal", cand_ok[0], 0);
    chk(sel_idx == 2'd1,    "R5 failover on loss", sel_idx, 1);
    chk(holdover == 1'b0,   "R6 no holdover on loss", holdover, 0);
  endtask

  task automatic t_bounds();
    cnt_max = 12'd30;
    wait_cyc(150);
    chk(cand_ok == '0,    "R2 tight bound rejects all", cand_ok, 0);
    chk(holdover == 1'b1, "R6 holdover on bounds", holdover, 1);
    cnt_max = 12'd33;
    wait_cyc(350);
    chk(cand_ok == 4'hE,  "R4 requalify after bounds", cand_ok, 14);
    chk(sel_idx == 2'd1,  "R5 select 1", sel_idx, 1);
  endtask

  task automatic t_holdover();
    logic [13:0] kept;
    for (int i = 0; i < N; i++) en[i] = 0;
    wait_cyc(60);
    chk(holdover == 1'b1, "R6 all lost", holdover, 1);
    chk(sel_idx == 2'd1,  "R6 selection held", sel_idx, 1);
    kept = freq_est;
    chk(kept >= 14'd127 && kept <= 14'd129, "R7 estimate at holdover", kept, 128);
    wait_cyc(500);
    chk(freq_est == kept, "R8 frozen estimate", freq_est, kept);
  endtask

  task automatic t_exit();
    en[2] = 1;
    wait_cyc(350);
    chk(holdover == 1'b0,  "R6 leave holdover", holdover, 0);
    chk(sel_idx == 2'd2,   "R5 select 2", sel_idx, 2);
    chk(cand_ok == 4'b0100, "R4 only 2 qualified", cand_ok, 4);
  endtask

  initial begin
    t_reset();
    t_qualify();
    t_drift();
    t_requal();
    t_history();
    t_los();
    t_bounds();
    t_holdover();
    t_exit();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule